// File: doc/BRIEF.md
# Microcontroller Low-Power Mode Sequencer

This block decides when a small 8-bit controller core stops executing and when it starts again. Software arms one of three halt modes by writing control bits: a light halt in which the system clock and peripherals keep running, a deep halt that also shuts the internal oscillator and all interrupt and timer activity, and an oscillator-driven sleep that powers down in the same way but can be woken by selected peripheral events. The block turns the armed mode into three enables: a CPU halt, a peripheral clock enable and an internal oscillator enable.

Entry into any mode is deferred until the instruction that armed it retires, which the core signals with a one-cycle retire strobe. Each mode has its own exit rule. The light halt ends on an enabled interrupt. The sleep mode ends on a peripheral wake event and then holds the CPU through an oscillator settle window. The deep halt ends only through reset. A watchdog reset or an external reset ends every mode and requests a restart from address 0x0000. A wake condition that arrives while a mode is still armed but not yet entered cancels the entry, so the core cannot lock up.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: During and right after reset (`rst_i`), `cpu_halt_o`=0, `periph_clk_en_o`=1, `int_osc_en_o`=1, all three mode bits read 0 and `cpu_restart_o`=1. `cpu_restart_o` returns to 0 one cycle after reset is released.
- R2: A control write (`ctl_we_i`) with `ctl_idle_i`=1 sets `idle_bit_o` on the next cycle. `cpu_halt_o` stays 0 until a cycle with `instr_done_i`=1 and rises on the following cycle. While idle, `periph_clk_en_o` and `int_osc_en_o` stay 1.
- R3: While idle, `irq_i`=1 clears `idle_bit_o` and drops `cpu_halt_o` on the next cycle.
- R4: A control write with `ctl_stop_i`=1 arms the deep halt. Entry is deferred to retire, as in R2. In the deep halt, `cpu_halt_o`=1, `periph_clk_en_o`=0 and `int_osc_en_o`=0. Neither `irq_i` nor `wake_evt_i` changes any output.
- R5: A control write with both `ctl_idle_i` and `ctl_stop_i` at 1 sets only `stop_bit_o`. `idle_bit_o` stays 0.
- R6: `wdt_rst_i`=1 ends any mode, the deep halt included. On the next cycle all mode bits are 0, `cpu_halt_o`=0, both enables are 1 and `cpu_restart_o`=1.
- R7: An oscillator-control write (`osc_we_i`) with `osc_susp_i`=1 sets `suspend_bit_o`. At retire, the block enters sleep with `cpu_halt_o`=1, `int_osc_en_o`=0 and `periph_clk_en_o`=0. `irq_i` does not wake it.
- R8: In sleep, any bit of `wake_evt_i` wakes the block. Bit 0 is port mismatch, bit 1 is comparator low and bit 2 is timer overflow. On the next cycle `suspend_bit_o`=0 and `int_osc_en_o`=1. `cpu_halt_o` remains 1 and `periph_clk_en_o` remains 0 for exactly SETTLE_CYC (8) cycles, after which both return to run values.
- R9: If `irq_i` arrives while `idle_bit_o`=1 but before entry, the idle bit clears and no halt follows. The same happens for a `wake_evt_i` bit while `suspend_bit_o` is armed. A wake in the same cycle as the retire strobe also wins.
- R10: Control and oscillator writes issued while the CPU is halted leave the mode bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_i | input | 1 | Synchronous external reset, active high |
| wdt_rst_i | input | 1 | Watchdog reset request, synchronous, active high |
| ctl_we_i | input | 1 | Write strobe for the power control bits |
| ctl_idle_i | input | 1 | Idle-select value written |
| ctl_stop_i | input | 1 | Stop-select value written |
| osc_we_i | input | 1 | Write strobe for the oscillator sleep bit |
| osc_susp_i | input | 1 | Sleep-select value written |
| instr_done_i | input | 1 | Retire strobe of the current instruction |
| irq_i | input | 1 | An enabled interrupt is asserted |
| wake_evt_i | input | N_WAKE | Peripheral wake events: port mismatch, comparator low, timer overflow |
| cpu_halt_o | output | 1 | Holds the CPU halted |
| periph_clk_en_o | output | 1 | Peripheral clock enable |
| int_osc_en_o | output | 1 | Internal oscillator enable |
| idle_bit_o | output | 1 | Idle-select bit value |
| stop_bit_o | output | 1 | Stop-select bit value |
| suspend_bit_o | output | 1 | Sleep-select bit value |
| cpu_restart_o | output | 1 | Request to restart execution at address 0x0000 |

## Verification
The same arm-retire-wake pattern is run once for each mode. This shows that the three modes gate clocks differently and accept different wake sources: an interrupt must end the light halt but not the sleep mode, and nothing but reset may end the deep halt. Each wake-event bit is driven on its own, with the settle window counted cycle by cycle, which checks that every event source reaches the wake logic and that the hold lasts exactly eight cycles. Further patterns cover a wake that arrives before the retire strobe, a wake that arrives together with it, a write of both select bits at once, and writes issued while halted. These tell deferred entry apart from immediate entry, and show priority and write gating.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,
        ST_IDLE   = 3'd1,
        ST_STOP   = 3'd2,
        ST_SUSP   = 3'd3,
        ST_SETTLE = 3'd4
    } pmc_state_e;

    typedef struct packed {
        logic idle;
        logic stop;
        logic susp;
    } pmc_bits_t;

    typedef struct packed {
        logic halt;
        logic periph_en;
        logic osc_en;
    } pmc_gate_t;

    function automatic pmc_gate_t gate_of(pmc_state_e st);
        pmc_gate_t g;
        case (st)
            ST_IDLE:   g = '{halt: 1'b1, periph_en: 1'b1, osc_en: 1'b1};
            ST_STOP:   g = '{halt: 1'b1, periph_en: 1'b0, osc_en: 1'b0};
            ST_SUSP:   g = '{halt: 1'b1, periph_en: 1'b0, osc_en: 1'b0};
            ST_SETTLE: g = '{halt: 1'b1, periph_en: 1'b0, osc_en: 1'b1};
            default:   g = '{halt: 1'b0, periph_en: 1'b1, osc_en: 1'b1};
        endcase
        return g;
    endfunction

endpackage

// File: rtl/pmc_regs.sv
module pmc_regs
    import pmc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_all,
    input  logic      wr_ok,
    input  logic      ctl_we,
    input  logic      ctl_idle,
    input  logic      ctl_stop,
    input  logic      osc_we,
    input  logic      osc_susp,
    input  logic      clr_idle,
    input  logic      clr_susp,
    output pmc_bits_t bits
);

    always_ff @(posedge clk) begin
        if (rst_all) begin
            bits <= '0;
        end else begin
            if (wr_ok && ctl_we) begin
                bits.stop <= ctl_stop;
                bits.idle <= ctl_idle & ~ctl_stop;
            end else if (clr_idle) begin
                bits.idle <= 1'b0;
            end
            if (wr_ok && osc_we) begin
                bits.susp <= osc_susp;
            end else if (clr_susp) begin
                bits.susp <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pmc_settle.sv
module pmc_settle #(
    parameter int SETTLE_CYC = 8
) (
    input  logic clk,
    input  logic rst_all,
    input  logic load,
    input  logic active,
    output logic done
);

    localparam int CW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [CW-1:0] LOAD_VAL = CW'(SETTLE_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst_all) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= LOAD_VAL;
        end else if (active && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);

endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
    import pmc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_all,
    input  pmc_bits_t  bits,
    input  logic       instr_done,
    input  logic       irq,
    input  logic       wake_any,
    input  logic       settle_done,
    output pmc_state_e state,
    output logic       wr_ok,
    output logic       clr_idle,
    output logic       clr_susp,
    output logic       settle_load
);

    pmc_state_e nxt;

    always_comb begin
        nxt         = state;
        clr_idle    = 1'b0;
        clr_susp    = 1'b0;
        settle_load = 1'b0;
        case (state)
            ST_RUN: begin
                if (bits.stop && instr_done) begin
                    nxt = ST_STOP;
                end else begin
                    clr_idle = bits.idle & irq;
                    clr_susp = bits.susp & wake_any;
                    if (instr_done) begin
                        if (bits.susp && !wake_any)      nxt = ST_SUSP;
                        else if (bits.idle && !irq)      nxt = ST_IDLE;
                    end
                end
            end
            ST_IDLE: begin
                if (irq) begin
                    clr_idle = 1'b1;
                    nxt      = ST_RUN;
                end
            end
            ST_SUSP: begin
                if (wake_any) begin
                    clr_susp    = 1'b1;
                    settle_load = 1'b1;
                    nxt         = ST_SETTLE;
                end
            end
            ST_SETTLE: begin
                if (settle_done) nxt = ST_RUN;
            end
            default: nxt = state;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst_all) state <= ST_RUN;
        else         state <= nxt;
    end

    assign wr_ok = (state == ST_RUN);

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int SETTLE_CYC = 8,
    parameter int N_WAKE     = 3
) (
    input  logic              clk,
    input  logic              rst_i,
    input  logic              wdt_rst_i,
    input  logic              ctl_we_i,
    input  logic              ctl_idle_i,
    input  logic              ctl_stop_i,
    input  logic              osc_we_i,
    input  logic              osc_susp_i,
    input  logic              instr_done_i,
    input  logic              irq_i,
    input  logic [N_WAKE-1:0] wake_evt_i,
    output logic              cpu_halt_o,
    output logic              periph_clk_en_o,
    output logic              int_osc_en_o,
    output logic              idle_bit_o,
    output logic              stop_bit_o,
    output logic              suspend_bit_o,
    output logic              cpu_restart_o
);

    logic       rst_all;
    logic       wake_any;
    logic       wr_ok, clr_idle, clr_susp, settle_load, settle_done;
    pmc_bits_t  bits;
    pmc_state_e state;
    pmc_gate_t  gate;
    logic       restart_q;

    assign rst_all  = rst_i | wdt_rst_i;
    assign wake_any = |wake_evt_i;

    pmc_regs u_regs (
        .clk      (clk),
        .rst_all  (rst_all),
        .wr_ok    (wr_ok),
        .ctl_we   (ctl_we_i),
        .ctl_idle (ctl_idle_i),
        .ctl_stop (ctl_stop_i),
        .osc_we   (osc_we_i),
        .osc_susp (osc_susp_i),
        .clr_idle (clr_idle),
        .clr_susp (clr_susp),
        .bits     (bits)
    );

    pmc_fsm u_fsm (
        .clk         (clk),
        .rst_all     (rst_all),
        .bits        (bits),
        .instr_done  (instr_done_i),
        .irq         (irq_i),
        .wake_any    (wake_any),
        .settle_done (settle_done),
        .state       (state),
        .wr_ok       (wr_ok),
        .clr_idle    (clr_idle),
        .clr_susp    (clr_susp),
        .settle_load (settle_load)
    );

    pmc_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk     (clk),
        .rst_all (rst_all),
        .load    (settle_load),
        .active  (state == ST_SETTLE),
        .done    (settle_done)
    );

    always_ff @(posedge clk) begin
        restart_q <= rst_all;
    end

    assign gate            = gate_of(state);
    assign cpu_halt_o      = gate.halt;
    assign periph_clk_en_o = gate.periph_en;
    assign int_osc_en_o    = gate.osc_en;
    assign idle_bit_o      = bits.idle;
    assign stop_bit_o      = bits.stop;
    assign suspend_bit_o   = bits.susp;
    assign cpu_restart_o   = restart_q;

endmodule

// File: rtl/pmc_chk.sv
module pmc_chk #(
    parameter int SETTLE_CYC = 8,
    parameter int N_WAKE     = 3
) (
    input logic              clk,
    input logic              rst_i,
    input logic              wdt_rst_i,
    input logic              irq_i,
    input logic [N_WAKE-1:0] wake_evt_i,
    input logic              cpu_halt_o,
    input logic              periph_clk_en_o,
    input logic              int_osc_en_o,
    input logic              idle_bit_o,
    input logic              stop_bit_o,
    input logic              suspend_bit_o,
    input logic              cpu_restart_o
);

    logic       in_settle;
    logic [7:0] settle_seen;

    assign in_settle = cpu_halt_o && int_osc_en_o && !periph_clk_en_o;

    always_ff @(posedge clk) begin
        if (rst_i || wdt_rst_i || !in_settle) settle_seen <= '0;
        else if (settle_seen != 8'hFF)         settle_seen <= settle_seen + 1'b1;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst_i |=> (cpu_restart_o && !cpu_halt_o && !idle_bit_o && !stop_bit_o && !suspend_bit_o));

    // R3
    idle_wake_chk: assert property (@(posedge clk) disable iff (rst_i || wdt_rst_i)
        (idle_bit_o && cpu_halt_o && irq_i) |=> (!cpu_halt_o && !idle_bit_o));

    // R4
    stop_hold_chk: assert property (@(posedge clk) disable iff (rst_i || wdt_rst_i)
        (stop_bit_o && cpu_halt_o) |=> (cpu_halt_o && !int_osc_en_o && !periph_clk_en_o));

    // R6
    wdt_exit_chk: assert property (@(posedge clk)
        wdt_rst_i |=> (!cpu_halt_o && int_osc_en_o && cpu_restart_o));

    // R7
    susp_irq_ignored_chk: assert property (@(posedge clk) disable iff (rst_i || wdt_rst_i)
        (suspend_bit_o && cpu_halt_o && irq_i && !(|wake_evt_i)) |=> cpu_halt_o);

    // R8
    susp_wake_chk: assert property (@(posedge clk) disable iff (rst_i || wdt_rst_i)
        (suspend_bit_o && cpu_halt_o && (|wake_evt_i)) |=> (cpu_halt_o && int_osc_en_o && !suspend_bit_o));

    // R8
    settle_len_chk: assert property (@(posedge clk) disable iff (rst_i || wdt_rst_i)
        in_settle |-> (32'(settle_seen) < SETTLE_CYC));

    // R8
    settle_release_chk: assert property (@(posedge clk) disable iff (rst_i || wdt_rst_i)
        (in_settle && 32'(settle_seen) == SETTLE_CYC - 1) |=> !cpu_halt_o);

    // R4
    osc_off_halts_chk: assert property (@(posedge clk) disable iff (rst_i || wdt_rst_i)
        !int_osc_en_o |-> cpu_halt_o);

endmodule

bind pwr_mode_ctrl pmc_chk #(.SETTLE_CYC(SETTLE_CYC), .N_WAKE(N_WAKE)) u_pmc_chk (
    .clk             (clk),
    .rst_i           (rst_i),
    .wdt_rst_i       (wdt_rst_i),
    .irq_i           (irq_i),
    .wake_evt_i      (wake_evt_i),
    .cpu_halt_o      (cpu_halt_o),
    .periph_clk_en_o (periph_clk_en_o),
    .int_osc_en_o    (int_osc_en_o),
    .idle_bit_o      (idle_bit_o),
    .stop_bit_o      (stop_bit_o),
    .suspend_bit_o   (suspend_bit_o),
    .cpu_restart_o   (cpu_restart_o)
);

// File: tb/test_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module test_pwr_mode_ctrl;

    localparam int SETTLE_CYC = 8;
    localparam int N_WAKE     = 3;

    logic clk = 1'b0;
    logic rst_i = 1'b1, wdt_rst_i = 1'b0;
    logic ctl_we_i = 1'b0, ctl_idle_i = 1'b0, ctl_stop_i = 1'b0;
    logic osc_we_i = 1'b0, osc_susp_i = 1'b0;
    logic instr_done_i = 1'b0, irq_i = 1'b0;
    logic [N_WAKE-1:0] wake_evt_i = '0;
    logic cpu_halt_o, periph_clk_en_o, int_osc_en_o;
    logic idle_bit_o, stop_bit_o, suspend_bit_o, cpu_restart_o;

    int total = 0;
    int bad   = 0;
    bit ended = 0;

    always #10 clk = ~clk;

    pwr_mode_ctrl #(.SETTLE_CYC(SETTLE_CYC), .N_WAKE(N_WAKE)) i_pwr_mode_ctrl (.*);

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_i = 1'b1; tick(); tick(); rst_i = 1'b0; tick();
    endtask

    task automatic write_ctl(input logic idle, input logic stop);
        ctl_we_i = 1'b1; ctl_idle_i = idle; ctl_stop_i = stop;
        tick();
        ctl_we_i = 1'b0; ctl_idle_i = 1'b0; ctl_stop_i = 1'b0;
    endtask

    task automatic write_osc(input logic s);
        osc_we_i = 1'b1; osc_susp_i = s; tick();
        osc_we_i = 1'b0; osc_susp_i = 1'b0;
    endtask

    task automatic retire();
        instr_done_i = 1'b1; tick(); instr_done_i = 1'b0;
    endtask

    task automatic t_reset();
        rst_i = 1'b1; tick();
        chk("R1", "halt in reset", cpu_halt_o, 0);
        chk("R1", "periph en", periph_clk_en_o, 1);
        chk("R1", "osc en", int_osc_en_o, 1);
        chk("R1", "bits", {idle_bit_o, stop_bit_o, suspend_bit_o}, 0);
        chk("R1", "restart", cpu_restart_o, 1);
        rst_i = 1'b0; tick();
        chk("R1", "restart after release", cpu_restart_o, 0);
    endtask

    task automatic t_idle();
        do_reset();
        write_ctl(1'b1, 1'b0);
        chk("R2", "idle bit set", idle_bit_o, 1);
        tick(); tick();
        chk("R2", "no halt before retire", cpu_halt_o, 0);
        retire();
        chk("R2", "halt after retire", cpu_halt_o, 1);
        chk("R2", "periph on in idle", periph_clk_en_o, 1);
        chk("R2", "osc on in idle", int_osc_en_o, 1);
        irq_i = 1'b1; tick(); irq_i = 1'b0;
        chk("R3", "halt released", cpu_halt_o, 0);
        chk("R3", "idle bit cleared", idle_bit_o, 0);
    endtask

    task automatic t_stop();
        do_reset();
        write_ctl(1'b0, 1'b1);
        chk("R4", "no halt before retire", cpu_halt_o, 0);
        retire();
        chk("R4", "halt", cpu_halt_o, 1);
        chk("R4", "osc off", int_osc_en_o, 0);
        chk("R4", "periph off", periph_clk_en_o, 0);
        irq_i = 1'b1; wake_evt_i = '1; tick(); tick(); tick();
        irq_i = 1'b0; wake_evt_i = '0;
        chk("R4", "irq/wake ignored halt", cpu_halt_o, 1);
        chk("R4", "irq/wake ignored osc", int_osc_en_o, 0);
        chk("R4", "stop bit kept", stop_bit_o, 1);
        wdt_rst_i = 1'b1; tick(); wdt_rst_i = 1'b0;
        chk("R6", "wdt ends stop halt", cpu_halt_o, 0);
        chk("R6", "wdt osc on", int_osc_en_o, 1);
        chk("R6", "wdt periph on", periph_clk_en_o, 1);
        chk("R6", "wdt clears stop", stop_bit_o, 0);
        chk("R6", "wdt restart", cpu_restart_o, 1);
        tick();
        chk("R6", "restart pulse ends", cpu_restart_o, 0);
    endtask

    task automatic t_wdt_idle();
        do_reset();
        write_ctl(1'b1, 1'b0); retire();
        wdt_rst_i = 1'b1; tick(); wdt_rst_i = 1'b0;
        chk("R6", "wdt ends idle", cpu_halt_o, 0);
        chk("R6", "wdt clears idle", idle_bit_o, 0);
    endtask

    task automatic t_priority();
        do_reset();
        write_ctl(1'b1, 1'b1);
        chk("R5", "stop bit", stop_bit_o, 1);
        chk("R5", "idle bit", idle_bit_o, 0);
        retire();
        chk("R5", "stop entered osc", int_osc_en_o, 0);
    endtask

    task automatic t_suspend(input int k);
        do_reset();
        write_osc(1'b1);
        chk("R7", "susp bit", suspend_bit_o, 1);
        retire();
        chk("R7", "halt", cpu_halt_o, 1);
        chk("R7", "osc off", int_osc_en_o, 0);
        chk("R7", "periph off", periph_clk_en_o, 0);
        irq_i = 1'b1; tick(); irq_i = 1'b0;
        chk("R7", "irq ignored", cpu_halt_o, 1);
        chk("R7", "irq ignored osc", int_osc_en_o, 0);
        wake_evt_i = '0; wake_evt_i[k] = 1'b1; tick(); wake_evt_i = '0;
        chk("R8", $sformatf("wake bit %0d osc on", k), int_osc_en_o, 1);
        chk("R8", "susp bit cleared", suspend_bit_o, 0);
        begin
            int held = 1;
            for (int i = 0; i < 20 && cpu_halt_o; i++) begin
                if (periph_clk_en_o) chk("R8", "periph off in settle", 1, 0);
                tick();
                if (cpu_halt_o) held++;
            end
            chk("R8", $sformatf("settle length bit %0d", k), held, SETTLE_CYC);
        end
        chk("R8", "periph on after settle", periph_clk_en_o, 1);
    endtask

    task automatic t_pending();
        do_reset();
        write_ctl(1'b1, 1'b0);
        irq_i = 1'b1; tick(); irq_i = 1'b0;
        chk("R9", "idle cancelled by early irq", idle_bit_o, 0);
        retire();
        chk("R9", "no idle halt", cpu_halt_o, 0);
        write_ctl(1'b1, 1'b0);
        irq_i = 1'b1; instr_done_i = 1'b1; tick(); irq_i = 1'b0; instr_done_i = 1'b0;
        chk("R9", "irq with retire: no halt", cpu_halt_o, 0);
        chk("R9", "irq with retire: bit clear", idle_bit_o, 0);
        write_osc(1'b1);
        wake_evt_i[1] = 1'b1; tick(); wake_evt_i = '0;
        chk("R9", "susp cancelled by early wake", suspend_bit_o, 0);
        retire();
        chk("R9", "no susp halt", cpu_halt_o, 0);
    endtask

    task automatic t_halted_write();
        do_reset();
        write_ctl(1'b1, 1'b0); retire();
        write_ctl(1'b0, 1'b1);
        chk("R10", "stop write while halted", stop_bit_o, 0);
        chk("R10", "idle kept while halted", idle_bit_o, 1);
        write_osc(1'b1);
        chk("R10", "susp write while halted", suspend_bit_o, 0);
        chk("R10", "still idle", cpu_halt_o, 1);
        chk("R10", "still idle osc", int_osc_en_o, 1);
        irq_i = 1'b1; tick(); irq_i = 1'b0;
    endtask

    initial begin
        t_reset();
        t_idle();
        t_stop();
        t_wdt_idle();
        t_priority();
        for (int k = 0; k < N_WAKE; k++) t_suspend(k);
        t_pending();
        t_halted_write();
        ended = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule